// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind an 8-bit host bus. Every channel has a count strobe input, a gate input and an active-low output. A strobe counts only while the gate is high. The host writes a control word to choose a channel's count format, binary or BCD. It then loads a 16-bit start value as two bytes. When the count runs out, the channel pulses its output low for one system clock, which can serve as a periodic interrupt. In the same clock the channel reloads its start value, so it keeps running.

All logic runs on one system clock. Each count input is a one-clock enable pulse sampled on that clock. A bus access takes one clock. Read data is driven combinationally while the read strobe is active, and the byte pointers advance at the clock edge that ends the access. A control word also copies the selected channel's running count into a holding register. The host can then read a stable value, low byte first and then high byte, while the counter keeps going.

Top module: `interval_timer3`

## Requirements
- R1: After reset all three outputs are high, every count and start value is zero, no channel is counting, and `rdata` is zero.
- R2: An access needs `cs_n` low. A write needs `wr_n` low and `rd_n` high. A read needs `rd_n` low and `wr_n` high. `addr` 0, 1 and 2 select channels 0, 1 and 2, and `addr` 3 selects the control word. Any other combination, and any read at `addr` 3, changes no state. `rdata` is zero whenever no channel read is in progress.
- R3: In a control word, bits [7:6] name the channel (3 = no channel, no effect) and bit 0 selects BCD (1) or binary (0). Bits [5:1] are ignored. The word resets the channel's write and read byte pointers.
- R4: Count bytes go in low byte first, then high byte. At the clock edge of the high-byte write, the count takes the full new 16-bit value, the start value is updated, and the channel begins counting.
- R5: In binary, a qualified strobe subtracts one modulo 65536. A start value of 0 gives a period of 65536 strobes, and its first step gives 0xFFFF.
- R6: In BCD, each of the four digits borrows from 0 to 9. A start value of 0 gives a period of 10000 strobes, and its first step gives 0x9999. For example, 0x1000 steps to 0x0999.
- R7: A channel's count changes only on a clock where its strobe and gate are both high, or on a high-byte write to it. With the gate low, strobes have no effect.
- R8: A qualified strobe that finds the count at 1 reloads the start value into the count. The channel's output is then low for the next clock only. No other event drives an output low.
- R9: Without a pending snapshot, reads return the live count, low byte first and then high byte. Reading does not alter the count.
- R10: A control word copies the channel's count, as it stood before that clock edge, into a snapshot. Reads of that channel return the snapshot until its high byte has been read, and after that return the live count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target select: 0 to 2 are channels, 3 is the control word |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, zero when no channel read is in progress |
| cnt_tick | input | 3 | Per-channel count strobe, one clock wide |
| cnt_gate | input | 3 | Per-channel count enable |
| out_n | output | 3 | Per-channel terminal-count pulse, active low |

## Verification
The bench targets the corners where a counter is easy to get wrong:
- A start value of 0 must wrap to 0xFFFF in binary and to 0x9999 in BCD. A design that treats 0 as an immediate terminal count would pulse at once.
- A BCD digit that reaches 0 must borrow to 9 and pass the borrow on. A plain binary subtractor would give 0x0FFF from 0x1000.
- A snapshot taken before a load must be read out ahead of the live value. A design that drops the snapshot early returns the new count in the middle of a pair.
- Deselected, half-strobed and address-3 accesses must leave the byte pointers alone. A design that toggles a pointer on them would assemble later loads with swapped bytes.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned CNT_W     = 2 * BUS_W;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned DIGIT_N   = CNT_W / 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  // One BCD step: digits borrow from 0 to 9, rippling upward.
  function automatic logic [CNT_W-1:0] bcd_step(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic             borrow;
    r      = v;
    borrow = 1'b1;
    for (int d = 0; d < int'(DIGIT_N); d++) begin
      if (borrow) begin
        if (v[4*d +: 4] == 4'd0) begin
          r[4*d +: 4] = 4'd9;
        end else begin
          r[4*d +: 4] = v[4*d +: 4] - 4'd1;
          borrow      = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v,
                                                  input logic             bcd);
    return bcd ? bcd_step(v) : (v - CNT_W'(1));
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
`timescale 1ns/1ps
module pit_bus_decode
  import pit_pkg::*;
(
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ctl_sel,
  output logic [NUM_CH-1:0] ch_wr,
  output logic [NUM_CH-1:0] ch_rd,
  output logic [NUM_CH-1:0] ctl_wr
);
  logic wr_ok;
  logic rd_ok;

  assign wr_ok = !cs_n && !wr_n && rd_n;
  assign rd_ok = !cs_n && !rd_n && wr_n;

  always_comb begin
    for (int i = 0; i < int'(NUM_CH); i++) begin
      ch_wr[i]  = wr_ok && (addr == ADDR_W'(i));
      ch_rd[i]  = rd_ok && (addr == ADDR_W'(i));
      ctl_wr[i] = wr_ok && (addr == CTRL_ADDR) && (ctl_sel == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cnt_gate,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             ctl_stb,
  input  logic             ctl_bcd,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rd_byte,
  output logic             out_n,
  output logic [CNT_W-1:0] count_mon,
  output logic             load_ev
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] snap_q;
  logic [BUS_W-1:0] lo_stage_q;
  logic             bcd_q;
  logic             armed_q;
  logic             wr_hi_q;
  logic             rd_hi_q;
  logic             snap_vld_q;
  logic             step_ev;
  logic             tc_ev;
  logic [CNT_W-1:0] rd_src;

  // Named internal events
  assign load_ev = wr_stb && wr_hi_q;
  assign step_ev = cnt_tick && cnt_gate && armed_q && !load_ev;
  assign tc_ev   = step_ev && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      start_q    <= '0;
      snap_q     <= '0;
      lo_stage_q <= '0;
      bcd_q      <= 1'b0;
      armed_q    <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      snap_vld_q <= 1'b0;
      out_n      <= 1'b1;
    end else begin
      out_n <= !tc_ev;

      if (ctl_stb) begin
        bcd_q      <= ctl_bcd;
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        snap_q     <= count_q;
        snap_vld_q <= 1'b1;
      end

      if (wr_stb) begin
        if (!wr_hi_q) begin
          lo_stage_q <= wdata;
          wr_hi_q    <= 1'b1;
        end else begin
          start_q <= {wdata, lo_stage_q};
          armed_q <= 1'b1;
          wr_hi_q <= 1'b0;
        end
      end

      if (rd_stb) begin
        rd_hi_q <= !rd_hi_q;
        if (rd_hi_q) snap_vld_q <= 1'b0;
      end

      if (load_ev) begin
        count_q <= {wdata, lo_stage_q};
      end else if (step_ev) begin
        count_q <= tc_ev ? start_q : count_step(count_q, bcd_q);
      end
    end
  end

  assign rd_src    = snap_vld_q ? snap_q : count_q;
  assign rd_byte   = rd_hi_q ? rd_src[CNT_W-1 -: BUS_W] : rd_src[BUS_W-1:0];
  assign count_mon = count_q;
endmodule

// File: rtl/interval_timer3.sv
`timescale 1ns/1ps
module interval_timer3
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [NUM_CH-1:0] cnt_tick,
  input  logic [NUM_CH-1:0] cnt_gate,
  output logic [NUM_CH-1:0] out_n
);
  logic [NUM_CH-1:0]            ch_wr;
  logic [NUM_CH-1:0]            ch_rd;
  logic [NUM_CH-1:0]            ctl_wr;
  logic [NUM_CH-1:0][BUS_W-1:0] rd_byte;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_mon;
  logic [NUM_CH-1:0]            load_mon;

  pit_bus_decode u_decode (
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .ctl_sel (wdata[BUS_W-1 -: ADDR_W]),
    .ch_wr   (ch_wr),
    .ch_rd   (ch_rd),
    .ctl_wr  (ctl_wr)
  );

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_chan
    pit_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_tick  (cnt_tick[g]),
      .cnt_gate  (cnt_gate[g]),
      .wr_stb    (ch_wr[g]),
      .rd_stb    (ch_rd[g]),
      .ctl_stb   (ctl_wr[g]),
      .ctl_bcd   (wdata[0]),
      .wdata     (wdata),
      .rd_byte   (rd_byte[g]),
      .out_n     (out_n[g]),
      .count_mon (cnt_mon[g]),
      .load_ev   (load_mon[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (ch_rd[i]) rdata = rd_byte[i];
    end
  end
endmodule

// File: rtl/pit_chk.sv
`timescale 1ns/1ps
module pit_chk
  import pit_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cs_n,
  input logic                            rd_n,
  input logic                            wr_n,
  input logic [ADDR_W-1:0]               addr,
  input logic [BUS_W-1:0]                rdata,
  input logic [NUM_CH-1:0]               cnt_tick,
  input logic [NUM_CH-1:0]               cnt_gate,
  input logic [NUM_CH-1:0]               out_n,
  input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_mon,
  input logic [NUM_CH-1:0]               load_mon
);
  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n || !wr_n || (addr == CTRL_ADDR)) |-> (rdata == '0));

  // R2
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || wr_n || !rd_n) |-> (load_mon == '0));

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_chk
    // R8
    out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_n[g] |-> $past(cnt_tick[g] && cnt_gate[g]));

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_gate[g] && !load_mon[g]) |=> $stable(cnt_mon[g]));

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick[g] && !load_mon[g]) |=> $stable(cnt_mon[g]));
  end
endmodule

bind interval_timer3 pit_chk u_pit_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .rdata    (rdata),
  .cnt_tick (cnt_tick),
  .cnt_gate (cnt_gate),
  .out_n    (out_n),
  .cnt_mon  (cnt_mon),
  .load_mon (load_mon)
);

// File: tb/interval_timer3_bench.sv
`timescale 1ns/1ps
module interval_timer3_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] cnt_tick = 3'd0;
  logic [2:0] cnt_gate = 3'd0;
  logic [2:0] out_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [2:0] g_gate = 3'd0;
  logic [7:0] last_rd;

  // Reference state, kept from the requirements
  logic [15:0] m_cnt [3];
  logic [15:0] m_start [3];
  logic [15:0] m_snap [3];
  logic [7:0]  m_lo [3];
  bit          m_bcd [3];
  bit          m_arm [3];
  bit          m_wrhi [3];
  bit          m_rdhi [3];
  bit          m_snapv [3];
  logic [2:0]  m_out_n;

  always #2.5 clk = ~clk;

  interval_timer3 u_interval_timer3 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .cnt_tick(cnt_tick), .cnt_gate(cnt_gate), .out_n(out_n)
  );

  // Decimal arithmetic restated through integers
  function automatic logic [15:0] ref_dec(input logic [15:0] v, input bit bcd);
    int d;
    if (!bcd) return v + 16'hFFFF;
    d = int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    d = (d + 9999) % 10000;
    return {4'(d / 1000), 4'((d / 100) % 10), 4'((d / 10) % 10), 4'(d % 10)};
  endfunction

  function automatic logic [7:0] rand_byte(input bit bcd);
    if (bcd) return {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
    return 8'($urandom);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_cnt[i] = '0; m_start[i] = '0; m_snap[i] = '0; m_lo[i] = '0;
      m_bcd[i] = 0; m_arm[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0; m_snapv[i] = 0;
    end
    m_out_n = 3'b111;
  endtask

  // One clock of bus and count activity, with model update and checks
  task automatic cyc(input bit c_n, input bit r_n, input bit w_n, input logic [1:0] a,
                     input logic [7:0] d, input logic [2:0] tk, input logic [2:0] gt,
                     input string tag);
    bit          is_rd, is_wr, ld, step, tc;
    logic [15:0] src, nxt;
    logic [7:0]  exp_b;
    @(negedge clk);
    cs_n = c_n; rd_n = r_n; wr_n = w_n; addr = a; wdata = d;
    cnt_tick = tk; cnt_gate = gt;
    #1;
    is_rd = !c_n && !r_n && w_n && (a != 2'd3);
    is_wr = !c_n && !w_n && r_n;
    if (is_rd) begin
      src   = m_snapv[a] ? m_snap[a] : m_cnt[a];
      exp_b = m_rdhi[a] ? src[15:8] : src[7:0];
      chk(rdata == exp_b, {m_snapv[a] ? "R10 snapshot read " : "R9 live read ", tag},
          16'(rdata), 16'(exp_b));
    end else begin
      chk(rdata == 8'd0, {"R2 idle rdata ", tag}, 16'(rdata), 16'd0);
    end
    last_rd = rdata;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      ld   = is_wr && (a == 2'(i)) && m_wrhi[i];
      step = tk[i] && gt[i] && m_arm[i] && !ld;
      tc   = step && (m_cnt[i] == 16'd1);
      nxt  = ld ? {d, m_lo[i]} : (step ? (tc ? m_start[i] : ref_dec(m_cnt[i], m_bcd[i])) : m_cnt[i]);
      m_out_n[i] = !tc;
      if (is_wr && (a == 2'd3) && (d[7:6] == 2'(i))) begin
        m_bcd[i] = d[0]; m_wrhi[i] = 0; m_rdhi[i] = 0;
        m_snap[i] = m_cnt[i]; m_snapv[i] = 1;
      end
      if (is_wr && (a == 2'(i))) begin
        if (!m_wrhi[i]) begin
          m_lo[i] = d; m_wrhi[i] = 1;
        end else begin
          m_start[i] = {d, m_lo[i]}; m_arm[i] = 1; m_wrhi[i] = 0;
        end
      end
      if (is_rd && (a == 2'(i))) begin
        if (m_rdhi[i]) m_snapv[i] = 0;
        m_rdhi[i] = !m_rdhi[i];
      end
      m_cnt[i] = nxt;
    end
    #1;
    chk(out_n == m_out_n, {"R8 outputs ", tag}, 16'(out_n), 16'(m_out_n));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(0, 1, 0, a, d, 3'd0, g_gate, tag);
  endtask

  task automatic tick(input logic [2:0] tk, input string tag);
    cyc(1, 1, 1, 2'd0, 8'd0, tk, g_gate, tag);
  endtask

  task automatic rd16(input logic [1:0] ch, input logic [15:0] exp, input string tag);
    logic [7:0] lo;
    cyc(0, 0, 1, ch, 8'd0, 3'd0, g_gate, tag);
    lo = last_rd;
    cyc(0, 0, 1, ch, 8'd0, 3'd0, g_gate, tag);
    chk({last_rd, lo} == exp, tag, {last_rd, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b5e_ed07));
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    chk(out_n == 3'b111, "R1 reset outputs", 16'(out_n), 16'h7);
    chk(rdata == 8'd0, "R1 reset rdata", 16'(rdata), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R10: snapshot of the pre-load count comes out first
    wr(2'd3, 8'h00, "R3 ctrl ch0 binary");
    wr(2'd0, 8'h03, "R4 low byte");
    wr(2'd0, 8'h00, "R4 high byte");
    rd16(2'd0, 16'h0000, "R10 snapshot before load");
    rd16(2'd0, 16'h0003, "R4 R9 live after load");

    // R7: gate low blocks strobes
    repeat (5) tick(3'b001, "R7 gate low");
    rd16(2'd0, 16'h0003, "R7 count held with gate low");

    // R8: terminal count and reload
    g_gate = 3'b001;
    tick(3'b001, "R5 step");
    tick(3'b001, "R5 step");
    chk(out_n[0] == 1'b1, "R8 no pulse before count 1", 16'(out_n[0]), 16'h1);
    tick(3'b001, "R8 terminal");
    chk(out_n[0] == 1'b0, "R8 pulse at terminal", 16'(out_n[0]), 16'h0);
    tick(3'b000, "R8 after pulse");
    chk(out_n[0] == 1'b1, "R8 pulse one clock wide", 16'(out_n[0]), 16'h1);
    rd16(2'd0, 16'h0003, "R8 reloaded start value");
    g_gate = 3'b000;

    // R5: zero start value in binary
    wr(2'd3, 8'h40, "R3 ctrl ch1 binary");
    wr(2'd1, 8'h00, "R4 low byte");
    wr(2'd1, 8'h00, "R4 high byte");
    rd16(2'd1, 16'h0000, "R10 snapshot ch1");
    g_gate = 3'b010;
    tick(3'b010, "R5 wrap");
    rd16(2'd1, 16'hFFFF, "R5 zero wraps to FFFF");
    g_gate = 3'b000;

    // R6: BCD borrow and zero start value
    wr(2'd3, 8'h81, "R3 ctrl ch2 BCD");
    wr(2'd2, 8'h00, "R4 low byte");
    wr(2'd2, 8'h10, "R4 high byte");
    rd16(2'd2, 16'h0000, "R10 snapshot ch2");
    g_gate = 3'b100;
    tick(3'b100, "R6 borrow");
    rd16(2'd2, 16'h0999, "R6 1000 steps to 0999");
    wr(2'd2, 8'h00, "R4 low byte");
    wr(2'd2, 8'h00, "R4 high byte");
    tick(3'b100, "R6 wrap");
    rd16(2'd2, 16'h9999, "R6 zero wraps to 9999");
    g_gate = 3'b000;

    // R2: accesses that must do nothing
    cyc(1, 1, 0, 2'd0, 8'h55, 3'd0, 3'd0, "R2 write with cs_n high");
    cyc(0, 0, 0, 2'd0, 8'h66, 3'd0, 3'd0, "R2 both strobes low");
    cyc(0, 0, 1, 2'd3, 8'h00, 3'd0, 3'd0, "R2 read at address 3");
    rd16(2'd0, 16'h0003, "R2 ignored accesses leave ch0");
    wr(2'd0, 8'h05, "R2 pointer intact low");
    wr(2'd0, 8'h00, "R2 pointer intact high");
    rd16(2'd0, 16'h0005, "R2 byte order after ignored accesses");

    // R3: control word naming channel 3 has no effect
    wr(2'd3, 8'hC1, "R3 ctrl select 3");
    rd16(2'd0, 16'h0005, "R3 select 3 takes no snapshot");

    // Random phase; channel 2 stays BCD, others binary
    for (int n = 0; n < 4000; n++) begin
      int          op;
      logic [1:0]  ch;
      logic [2:0]  tk, gt;
      op = $urandom_range(0, 11);
      ch = 2'($urandom_range(0, 2));
      tk = 3'($urandom);
      gt = 3'($urandom) | 3'($urandom);
      case (op)
        0, 1, 2: cyc(0, 0, 1, ch, 8'd0, tk, gt, "R9 random read");
        3:       cyc(0, 1, 0, ch, rand_byte(ch == 2'd2), tk, gt, "R4 random load");
        4:       cyc(0, 1, 0, 2'd3, {ch, 5'($urandom), ch == 2'd2}, tk, gt, "R10 random ctrl");
        5:       cyc(0, 1, 0, 2'd3, {2'b11, 6'($urandom)}, tk, gt, "R3 random ctrl 3");
        6:       cyc(1, 3'($urandom) != 0, 1'($urandom), 2'($urandom), 8'($urandom), tk, gt, "R2 random deselect");
        default: cyc(1, 1, 1, 2'd0, 8'd0, tk, gt, "R7 random count");
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0, 2'd3, {2'(i), 5'd0, i == 2}, 3'd0, 3'd0, "R10 final ctrl");
      rd16(2'(i), m_snap[i], "R10 final snapshot");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule